// File: doc/BRIEF.md
# Transit Inner Label Classifier

This block sits on the receive path of a transit switch that carries encapsulated Ethernet frames. It watches the inner header one byte per cycle, starting at the first byte of the inner destination MAC address. It reads the 16-bit type value that follows the two inner MAC addresses. From that value it decides whether the frame carries a classic single 12-bit VLAN tag or the extended two-word label, which gives a 24-bit label space. It then produces the forwarding priority, the drop-eligible bit, the label, an error code and a discard decision.

The same cycle that carries the results also carries a prune-match flag for the distribution tree. The flag compares the frame label against a configured label under a configured mask. It can also restrict the compare to the upper or lower 12-bit half. All results are registered and appear together with a one-cycle done strobe. A VLAN-only setting lets a switch that must not forward extended-label traffic reject such frames at the type position.

Top module: `inner_label_classifier`

## Requirements
- R1: Byte 0 of a frame is the byte presented with `in_sof`. When bytes 12..13 (byte 12 most significant) hold 0x8100, the frame is VLAN-labelled and `out_done` pulses one cycle after byte 15. `out_fine`=0 and `out_label` = {12'h000, low 12 bits of the word in bytes 14..15}.
- R2: When bytes 12..13 hold 0x893B and VLAN-only mode is off, the frame is fine-labelled and `out_done` pulses one cycle after byte 19. `out_fine`=1 and `out_label` = {low 12 bits of bytes 14..15, low 12 bits of bytes 18..19}.
- R3: In both formats, `out_prio` is bits 15:13 and `out_dei` is bit 12 of the word in bytes 14..15.
- R4: With `cfg_vlan_only`=1, a 0x893B at bytes 12..13 ends classification one cycle after byte 13 with `out_err`=2 and `out_discard`=1. A 0x8100 frame is classified normally in this mode.
- R5: Any other value at bytes 12..13 ends classification one cycle after byte 13 with `out_err`=1 and `out_discard`=1.
- R6: For a fine-labelled frame whose bytes 16..17 are not 0x893B, classification ends one cycle after byte 17 with `out_err`=3, `out_discard`=1 and `out_fine`=1.
- R7: A frame whose `in_eof` byte comes before its last label byte ends one cycle after that byte with `out_err`=4 and `out_discard`=1. This includes a one-byte frame.
- R8: The effective mask is `cfg_prune_mask` ANDed with a part select: `cfg_prune_part` 0 or 3 selects all 24 bits, 1 selects bits 23:12 only, and 2 selects bits 11:0 only. `out_prune_hit`=1 when the label and `cfg_prune_label` agree on every effective-mask bit.
- R9: On a discarded frame, `out_label`, `out_prio`, `out_dei` and `out_prune_hit` are 0. `out_fine` still reports whether bytes 12..13 held 0x893B.
- R10: Bytes after classification ends, and bytes with `in_valid` low, have no effect until the next `in_sof`. Results hold their values between done pulses.
- R11: After reset, `out_done`, `out_err`, `out_discard`, `out_label` and `out_prune_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of the inner header |
| in_eof | input | 1 | Last byte of the frame |
| in_data | input | 8 | Stream byte |
| cfg_vlan_only | input | 1 | Reject extended-label frames |
| cfg_prune_label | input | 24 | Label compared for pruning |
| cfg_prune_mask | input | 24 | Bits taking part in the compare |
| cfg_prune_part | input | 2 | Half select for the compare |
| out_done | output | 1 | One-cycle result strobe |
| out_fine | output | 1 | First type was the extended-label value |
| out_prio | output | 3 | Forwarding priority |
| out_dei | output | 1 | Drop-eligible bit |
| out_label | output | 24 | VLAN ID or 24-bit label |
| out_err | output | 3 | 0 none, 1 type, 2 mode, 3 second type, 4 truncated |
| out_discard | output | 1 | Frame must be dropped |
| out_prune_hit | output | 1 | Label matches the prune configuration |

## Verification
The bench times each done pulse against the index of the byte that settled the result. A design that counted offsets from the wrong byte, or that waited for the end of the frame, would strobe at the wrong index. Extended frames are sent with idle gaps and long payloads, so a counter that advanced on idle cycles, or logic that re-classified payload bytes, would report a second pulse or a changed label. Prune cases use a label that matches only in one half or only under the mask, which exposes a swapped half select or an ignored mask. Discard cases use a match-all mask, so a design that did not clear the hit flag on discard shows up. Truncation is exercised at a single byte and just short of each format's end.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam logic [15:0] TYPE_VLAN = 16'h8100;
  localparam logic [15:0] TYPE_FINE = 16'h893B;

  // Byte index of the low byte of each header word, counted from in_sof
  localparam int OFF_TYPE1 = 13;
  localparam int OFF_WORD1 = 15;
  localparam int OFF_TYPE2 = 17;
  localparam int OFF_WORD2 = 19;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_TYPE   = 3'd1,
    ERR_MODE   = 3'd2,
    ERR_SECOND = 3'd3,
    ERR_TRUNC  = 3'd4
  } err_e;
endpackage

// File: rtl/ilc_byte_index.sv
module ilc_byte_index #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sof,
  input  logic             frame_stop,
  output logic             take,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             active_q, active_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  assign take = byte_vld & (byte_sof | active_q);
  assign idx  = byte_sof ? '0 : cnt_q;

  always_comb begin
    active_d = ~frame_stop;
    cnt_d    = (idx == IDX_MAX) ? idx : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/ilc_prune_match.sv
module ilc_prune_match #(
  parameter int HALF_W = 12
) (
  input  logic [2*HALF_W-1:0] label,
  input  logic [2*HALF_W-1:0] ref_label,
  input  logic [2*HALF_W-1:0] ref_mask,
  input  logic [1:0]          part,
  output logic                hit
);
  localparam int LABEL_W = 2 * HALF_W;

  logic [LABEL_W-1:0] miss;

  for (genvar b = 0; b < LABEL_W; b++) begin : g_bit
    logic part_en;
    if (b >= HALF_W) begin : g_high
      assign part_en = (part != 2'd2);
    end else begin : g_low
      assign part_en = (part != 2'd1);
    end
    assign miss[b] = part_en & ref_mask[b] & (label[b] ^ ref_label[b]);
  end

  assign hit = ~|miss;
endmodule

// File: rtl/inner_label_classifier.sv
module inner_label_classifier
  import ilc_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic [7:0]          in_data,
  input  logic                cfg_vlan_only,
  input  logic [2*HALF_W-1:0] cfg_prune_label,
  input  logic [2*HALF_W-1:0] cfg_prune_mask,
  input  logic [1:0]          cfg_prune_part,
  output logic                out_done,
  output logic                out_fine,
  output logic [2:0]          out_prio,
  output logic                out_dei,
  output logic [2*HALF_W-1:0] out_label,
  output logic [2:0]          out_err,
  output logic                out_discard,
  output logic                out_prune_hit
);
  localparam int LABEL_W = 2 * HALF_W;
  localparam logic [IDX_W-1:0] IDX_T1 = IDX_W'(OFF_TYPE1);
  localparam logic [IDX_W-1:0] IDX_W1 = IDX_W'(OFF_WORD1);
  localparam logic [IDX_W-1:0] IDX_T2 = IDX_W'(OFF_TYPE2);
  localparam logic [IDX_W-1:0] IDX_W2 = IDX_W'(OFF_WORD2);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic             take;
  logic [IDX_W-1:0] idx;
  logic             fin;
  logic             ok;
  err_e             err_d;
  logic [7:0]       hi_q, hi_d;
  logic             fine_q, fine_d;
  logic [15:0]      w1_q, w1_d, w1_use;
  logic [15:0]      word;
  logic [LABEL_W-1:0] lbl_d;
  logic             hit_w;

  ilc_byte_index #(.IDX_W(IDX_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_q),
    .byte_vld   (in_valid),
    .byte_sof   (in_sof),
    .frame_stop (fin),
    .take       (take),
    .idx        (idx)
  );

  ilc_prune_match #(.HALF_W(HALF_W)) u_prune (
    .label     (lbl_d),
    .ref_label (cfg_prune_label),
    .ref_mask  (cfg_prune_mask),
    .part      (cfg_prune_part),
    .hit       (hit_w)
  );

  // Header walk: decides format, errors and label at the settling byte
  always_comb begin
    word   = {hi_q, in_data};
    hi_d   = hi_q;
    fine_d = fine_q;
    w1_d   = w1_q;
    w1_use = w1_q;
    lbl_d  = '0;
    fin    = 1'b0;
    err_d  = ERR_NONE;
    if (take) begin
      if (!idx[0]) hi_d = in_data;
      if (idx == '0) fine_d = 1'b0;
      if (idx == IDX_T1) begin
        if (word == TYPE_VLAN) begin
          fine_d = 1'b0;
        end else if (word == TYPE_FINE) begin
          fine_d = 1'b1;
          if (cfg_vlan_only) begin
            fin   = 1'b1;
            err_d = ERR_MODE;
          end
        end else begin
          fine_d = 1'b0;
          fin    = 1'b1;
          err_d  = ERR_TYPE;
        end
      end else if (idx == IDX_W1) begin
        w1_d   = word;
        w1_use = word;
        if (!fine_q) begin
          fin   = 1'b1;
          lbl_d = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
        end
      end else if (idx == IDX_T2) begin
        if (word != TYPE_FINE) begin
          fin   = 1'b1;
          err_d = ERR_SECOND;
        end
      end else if (idx == IDX_W2) begin
        fin   = 1'b1;
        lbl_d = {w1_q[HALF_W-1:0], word[HALF_W-1:0]};
      end
      if (!fin && in_eof) begin
        fin   = 1'b1;
        err_d = ERR_TRUNC;
      end
    end
    ok = fin && (err_d == ERR_NONE);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hi_q   <= '0;
      fine_q <= 1'b0;
      w1_q   <= '0;
    end else if (take) begin
      hi_q   <= hi_d;
      fine_q <= fine_d;
      w1_q   <= w1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_done <= 1'b0;
    end else begin
      out_done <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_fine      <= 1'b0;
      out_prio      <= '0;
      out_dei       <= 1'b0;
      out_label     <= '0;
      out_err       <= '0;
      out_discard   <= 1'b0;
      out_prune_hit <= 1'b0;
    end else if (fin) begin
      out_fine      <= fine_d;
      out_prio      <= ok ? w1_use[15:13] : 3'd0;
      out_dei       <= ok & w1_use[12];
      out_label     <= ok ? lbl_d : '0;
      out_err       <= err_d;
      out_discard   <= ~ok;
      out_prune_hit <= ok & hit_w;
    end
  end
endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
  parameter int LABEL_W = 24
) (
  input logic               clk,
  input logic               rst_q,
  input logic               in_valid,
  input logic               in_sof,
  input logic               in_eof,
  input logic               cfg_vlan_only,
  input logic               out_done,
  input logic               out_fine,
  input logic [LABEL_W-1:0] out_label,
  input logic [2:0]         out_err,
  input logic               out_discard,
  input logic               out_prune_hit
);
  localparam int HALF_W = LABEL_W / 2;

  // R4: extended frame under VLAN-only mode is always dropped
  p_mode_discard_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (out_done && out_fine && $past(cfg_vlan_only)) |-> out_discard);

  // R9: dropped frames carry no label and no prune hit
  p_discard_clears_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_done && out_discard) |-> (out_label == '0 && !out_prune_hit));

  // R7: a one-byte frame ends as truncated on the next cycle
  p_single_byte_trunc_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_sof && in_eof) |=> (out_done && out_err == 3'd4));

  // R1: a VLAN result leaves the upper label half clear
  p_vlan_high_zero_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (out_done && !out_discard && !out_fine) |-> (out_label[LABEL_W-1:HALF_W] == '0));

  // R10: results hold between done pulses
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !out_done |-> ($stable(out_label) && $stable(out_err)));

  // R10: a done pulse always follows an accepted byte
  p_done_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_q)
    out_done |-> $past(in_valid));
endmodule

bind inner_label_classifier ilc_checker #(.LABEL_W(2*HALF_W)) u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .in_valid      (in_valid),
  .in_sof        (in_sof),
  .in_eof        (in_eof),
  .cfg_vlan_only (cfg_vlan_only),
  .out_done      (out_done),
  .out_fine      (out_fine),
  .out_label     (out_label),
  .out_err       (out_err),
  .out_discard   (out_discard),
  .out_prune_hit (out_prune_hit)
);

// File: tb/inner_label_classifier_test.sv
`timescale 1ns/1ps
module inner_label_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        cfg_vlan_only = 1'b0;
  logic [23:0] cfg_prune_label = 24'h0, cfg_prune_mask = 24'hFFFFFF;
  logic [1:0]  cfg_prune_part = 2'd0;
  logic        out_done, out_fine, out_dei, out_discard, out_prune_hit;
  logic [2:0]  out_prio, out_err;
  logic [23:0] out_label;

  int errors = 0, checks = 0;
  int drv_idx = 0, taken_idx = 0;
  int done_cnt = 0, done_at = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  inner_label_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .cfg_vlan_only(cfg_vlan_only),
    .cfg_prune_label(cfg_prune_label), .cfg_prune_mask(cfg_prune_mask),
    .cfg_prune_part(cfg_prune_part), .out_done(out_done), .out_fine(out_fine),
    .out_prio(out_prio), .out_dei(out_dei), .out_label(out_label),
    .out_err(out_err), .out_discard(out_discard), .out_prune_hit(out_prune_hit)
  );

  always @(posedge clk) if (in_valid) taken_idx <= drv_idx;

  always @(negedge clk) begin
    if (out_done) begin
      done_cnt = done_cnt + 1;
      done_at  = taken_idx;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [15:0] t1, w1, t2, w2);
    case (i)
      12: return t1[15:8];
      13: return t1[7:0];
      14: return w1[15:8];
      15: return w1[7:0];
      16: return t2[15:8];
      17: return t2[7:0];
      18: return w2[15:8];
      19: return w2[7:0];
      default: return (i < 12) ? 8'(8'hA0 + i) : 8'h55;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [23:0] lbl, cl, m, input logic [1:0] part);
    logic [23:0] eff;
    eff = m & ((part == 2'd1) ? 24'hFFF000 : (part == 2'd2) ? 24'h000FFF : 24'hFFFFFF);
    return ((lbl ^ cl) & eff) == 24'h0;
  endfunction

  task automatic run_frame(input logic [15:0] t1, w1, t2, w2, input int len, input bit gaps);
    done_cnt = 0;
    done_at  = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      drv_idx  = i;
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = fbyte(i, t1, w1, t2, w2);
      if (gaps && i[0]) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 done", out_done, 0);
    chk("R11 err", out_err, 0);
    chk("R11 discard", out_discard, 0);
    chk("R11 label", out_label, 0);
    chk("R11 hit", out_prune_hit, 0);
  endtask

  task automatic t_vlan;
    cfg_prune_label = 24'h000123; cfg_prune_mask = 24'hFFFFFF; cfg_prune_part = 2'd0;
    run_frame(16'h8100, 16'hA123, 16'h0, 16'h0, 16, 0);
    chk("R1 count", done_cnt, 1);
    chk("R1 timing", done_at, 15);
    chk("R1 fine", out_fine, 0);
    chk("R1 label", out_label, 24'h000123);
    chk("R3 prio vlan", out_prio, 5);
    chk("R3 dei vlan", out_dei, 0);
    chk("R1 err", out_err, 0);
    chk("R8 hit vlan", out_prune_hit, exp_hit(24'h000123, cfg_prune_label, cfg_prune_mask, cfg_prune_part));
  endtask

  task automatic t_fine;
    cfg_prune_label = 24'hABC999; cfg_prune_part = 2'd1;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 20, 0);
    chk("R2 timing", done_at, 19);
    chk("R2 fine", out_fine, 1);
    chk("R2 label", out_label, 24'hABC456);
    chk("R3 prio fine", out_prio, 1);
    chk("R3 dei fine", out_dei, 1);
    chk("R8 high half hit", out_prune_hit, 1);
    cfg_prune_part = 2'd0;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 28, 1);
    chk("R10 gaps count", done_cnt, 1);
    chk("R10 gaps timing", done_at, 19);
    chk("R10 gaps label", out_label, 24'hABC456);
    chk("R8 whole miss", out_prune_hit, 0);
    cfg_prune_label = 24'h000456; cfg_prune_part = 2'd2;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 20, 0);
    chk("R8 low half hit", out_prune_hit, 1);
    cfg_prune_label = 24'hABC457; cfg_prune_mask = 24'hFFFFFE; cfg_prune_part = 2'd3;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 20, 0);
    chk("R8 masked hit", out_prune_hit, exp_hit(24'hABC456, 24'hABC457, 24'hFFFFFE, 2'd3));
  endtask

  task automatic t_mode;
    cfg_vlan_only = 1'b1; cfg_prune_mask = 24'h0;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 20, 0);
    chk("R4 timing", done_at, 13);
    chk("R4 err", out_err, 2);
    chk("R4 discard", out_discard, 1);
    chk("R9 fine kept", out_fine, 1);
    chk("R9 label zero", out_label, 0);
    chk("R9 hit zero", out_prune_hit, 0);
    chk("R9 prio zero", out_prio, 0);
    run_frame(16'h8100, 16'h4777, 16'h0, 16'h0, 16, 0);
    chk("R4 vlan ok err", out_err, 0);
    chk("R4 vlan ok label", out_label, 24'h000777);
    cfg_vlan_only = 1'b0; cfg_prune_mask = 24'hFFFFFF;
  endtask

  task automatic t_bad_types;
    run_frame(16'h0800, 16'h3ABC, 16'h893B, 16'hF456, 20, 0);
    chk("R5 timing", done_at, 13);
    chk("R5 err", out_err, 1);
    chk("R5 discard", out_discard, 1);
    chk("R9 fine clear", out_fine, 0);
    run_frame(16'h893B, 16'h3ABC, 16'h8100, 16'hF456, 20, 0);
    chk("R6 timing", done_at, 17);
    chk("R6 err", out_err, 3);
    chk("R6 fine", out_fine, 1);
    chk("R6 label zero", out_label, 0);
  endtask

  task automatic t_trunc;
    run_frame(16'h893B, 16'h3ABC, 16'h893B, 16'hF456, 17, 0);
    chk("R7 fine timing", done_at, 16);
    chk("R7 fine err", out_err, 4);
    run_frame(16'h8100, 16'h3ABC, 16'h0, 16'h0, 15, 0);
    chk("R7 vlan timing", done_at, 14);
    chk("R7 vlan err", out_err, 4);
    run_frame(16'h8100, 16'h3ABC, 16'h0, 16'h0, 1, 0);
    chk("R7 single timing", done_at, 0);
    chk("R7 single err", out_err, 4);
    chk("R7 single discard", out_discard, 1);
  endtask

  task automatic t_hold;
    run_frame(16'h8100, 16'h2ABD, 16'h893B, 16'h1111, 40, 0);
    chk("R10 long count", done_cnt, 1);
    chk("R10 long label", out_label, 24'h000ABD);
    done_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 19);
      in_data = 8'h89;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 stray count", done_cnt, 0);
    chk("R10 stray label", out_label, 24'h000ABD);
    chk("R10 stray err", out_err, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_vlan();
    t_fine();
    t_mode();
    t_bad_types();
    t_trunc();
    t_hold();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end
endmodule